// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block brings a DDR SDRAM interface from reset to a usable state. After a start pulse it first waits out an impedance-calibration period, then issues two writes on a small configuration port: one to the calibration control register and one to the drive-strength register. Through the whole run it keeps periodic refresh turned off and the data, strobe and check-bit pad drivers in high impedance. It then waits a deselect period and steps through a fixed series of SDRAM commands, with a programmable gap after each one.

When the last mode-register write has settled, the sequencer raises `done`, releases the pad drivers and passes the programmed refresh interval through to the controller. Every delay is a module parameter counted in clock cycles. The memory controller's command path drives `cmd` onto the bus whenever `cmd_stb` is high. Only a synchronous reset can restart the sequence.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, and while idle, the outputs are as follows: `cmd_stb`, `cfg_we`, `cke`, `done` and `ref_en` low, `pad_hiz` high, `cmd` = 4'b1111 and `ref_interval` = 0.
- R2: If `start` is sampled high at clock edge s, the first configuration write is visible in the cycle after edge s+CAL_CYCLES.
- R3: The configuration writes take two consecutive cycles. The first has `cfg_sel`=0 and data 32'h0000_1000 (calibration control). The second has `cfg_sel`=1 and data 32'h0002_08F0 (drive strength).
- R4: The first command (NOP) is strobed DESEL_CYCLES+1 cycles after the second configuration write. `cke` is low before that cycle, goes high in it, and stays high.
- R5: Commands are strobed in this order and with these codes: NOP 0011, precharge-all 0010, extended mode set 0100, mode set with DLL reset 0001, precharge-all 0010, auto-refresh 0110, auto-refresh 0110, mode set without DLL reset 0000.
- R6: The distance from one strobe to the next is 2 cycles after the NOP, TRP+1 after each precharge-all, TMRD+1 after the extended mode set and after the first mode set, and TRFC+1 after each auto-refresh.
- R7: `done` rises TMRD+1 cycles after the final mode-set strobe. In that same cycle `pad_hiz` falls and `ref_en` rises. From then on `ref_interval` equals `ref_prog`. Before that cycle it is 0.
- R8: `cmd_stb` is high for one cycle per command. When it is low, `cmd` reads 4'b1111.
- R9: A `start` pulse while the sequence is running, or after `done`, has no effect on outputs or timing.
- R10: Reset asserted mid-sequence returns all outputs to the R1 state on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence (accepted only when idle) |
| ref_prog | input | REF_W | Refresh interval to apply after initialization |
| cmd | output | 4 | SDRAM command code |
| cmd_stb | output | 1 | One-cycle strobe for `cmd` |
| cke | output | 1 | SDRAM clock enable |
| pad_hiz | output | 1 | High: data, strobe and check-bit drivers tri-stated |
| ref_en | output | 1 | Periodic refresh enabled |
| ref_interval | output | REF_W | Refresh interval in effect (0 during init) |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_sel | output | 1 | Target register: 0 calibration control, 1 drive strength |
| cfg_wdata | output | 32 | Configuration write data |
| done | output | 1 | Initialization complete; row activates permitted |

## Verification
The results of a run are timed from the edge s that samples `start`. The first configuration write is due CAL_CYCLES cycles later and the NOP DESEL_CYCLES+2 cycles after that. Each later strobe follows the one before it by its wait plus one cycle, and `done` follows the final mode set by TMRD+1 cycles. The bench turns these rules into an expected cycle offset for every write and strobe and queues them. A monitor samples on the falling edge, counts cycles since s, and compares each write and strobe against the queue by value and by offset. The level outputs (`cke`, `pad_hiz`, `ref_interval`, `done`) are checked every cycle against the same offsets.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CAL_CYCLES   = 1700000,
  parameter int DESEL_CYCLES = 10000,
  parameter int TMRD         = 2,
  parameter int TRP          = 3,
  parameter int TRFC         = 14,
  parameter int REF_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [REF_W-1:0] ref_prog,
  output logic [3:0]       cmd,
  output logic             cmd_stb,
  output logic             cke,
  output logic             pad_hiz,
  output logic             ref_en,
  output logic [REF_W-1:0] ref_interval,
  output logic             cfg_we,
  output logic             cfg_sel,
  output logic [31:0]      cfg_wdata,
  output logic             done
);

  localparam int MAX_A = (CAL_CYCLES > DESEL_CYCLES) ? CAL_CYCLES : DESEL_CYCLES;
  localparam int MAX_B = (TRFC > TRP) ? TRFC : TRP;
  localparam int MAX_C = (TMRD > MAX_B) ? TMRD : MAX_B;
  localparam int MAX_D = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W = $clog2(MAX_D + 1);
  localparam int LAST  = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_CAL, S_CFG0, S_CFG1, S_DESEL, S_CMD, S_WAIT, S_DONE
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       step;

  function automatic logic [3:0] step_code(input logic [2:0] k);
    case (k)
      3'd0:    step_code = 4'b0011;
      3'd1:    step_code = 4'b0010;
      3'd2:    step_code = 4'b0100;
      3'd3:    step_code = 4'b0001;
      3'd4:    step_code = 4'b0010;
      3'd5:    step_code = 4'b0110;
      3'd6:    step_code = 4'b0110;
      default: step_code = 4'b0000;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] step_gap(input logic [2:0] k);
    int g;
    case (k)
      3'd0:            g = 1;
      3'd1, 3'd4:      g = TRP;
      3'd5, 3'd6:      g = TRFC;
      default:         g = TMRD;
    endcase
    step_gap = CNT_W'(g - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      step <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_CAL;
          cnt <= CNT_W'(CAL_CYCLES - 1);
        end
        S_CAL: if (cnt == 0) st <= S_CFG0; else cnt <= cnt - 1'b1;
        S_CFG0: st <= S_CFG1;
        S_CFG1: begin
          st  <= S_DESEL;
          cnt <= CNT_W'(DESEL_CYCLES - 1);
        end
        S_DESEL: if (cnt == 0) begin
          st   <= S_CMD;
          step <= '0;
        end else cnt <= cnt - 1'b1;
        S_CMD: begin
          st  <= S_WAIT;
          cnt <= step_gap(step);
        end
        S_WAIT: if (cnt == 0) begin
          if (step == 3'(LAST)) st <= S_DONE;
          else begin
            step <= step + 1'b1;
            st   <= S_CMD;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_DONE;
      endcase
    end
  end

  assign cmd_stb      = (st == S_CMD);
  assign cmd          = cmd_stb ? step_code(step) : 4'b1111;
  assign cke          = (st == S_CMD) || (st == S_WAIT) || (st == S_DONE);
  assign done         = (st == S_DONE);
  assign pad_hiz      = !done;
  assign ref_en       = done;
  assign ref_interval = done ? ref_prog : '0;
  assign cfg_we       = (st == S_CFG0) || (st == S_CFG1);
  assign cfg_sel      = (st == S_CFG1);
  assign cfg_wdata    = (st == S_CFG0) ? 32'h0000_1000 :
                        (st == S_CFG1) ? 32'h0002_08F0 : 32'h0;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int REF_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       cmd,
  input logic             cmd_stb,
  input logic             cke,
  input logic             pad_hiz,
  input logic             ref_en,
  input logic [REF_W-1:0] ref_interval,
  input logic             cfg_we,
  input logic             done
);

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);

  // R8
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_stb |-> cmd == 4'b1111);

  // R4
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R4
  stb_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> cke);

  // R3
  cfg_before_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> !cke && pad_hiz && !cmd_stb);

  // R7
  refresh_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_interval != '0 || ref_en) |-> done);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !pad_hiz && !cmd_stb);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.REF_W(REF_W)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .cmd_stb(cmd_stb), .cke(cke),
  .pad_hiz(pad_hiz), .ref_en(ref_en), .ref_interval(ref_interval),
  .cfg_we(cfg_we), .done(done)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
  localparam int CAL = 20, DES = 12, TMRD = 2, TRP = 3, TRFC = 5, RW = 16;

  logic clk = 0, rst = 1, start = 0;
  logic [RW-1:0] ref_prog = '0;
  logic [3:0] cmd;
  logic cmd_stb, cke, pad_hiz, ref_en, cfg_we, cfg_sel, done;
  logic [RW-1:0] ref_interval;
  logic [31:0] cfg_wdata;

  ddr_init_seq #(.CAL_CYCLES(CAL), .DESEL_CYCLES(DES), .TMRD(TMRD), .TRP(TRP),
    .TRFC(TRFC), .REF_W(RW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .ref_prog(ref_prog), .cmd(cmd),
    .cmd_stb(cmd_stb), .cke(cke), .pad_hiz(pad_hiz), .ref_en(ref_en),
    .ref_interval(ref_interval), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done(done));

  always #10 clk = ~clk;

  typedef struct { bit is_cmd; logic [32:0] val; int rel; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, cyc = 0, t0 = 0, t_nop = 0, t_done = 0;
  bit active = 0, done_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    int rel;
    rel = cyc - t0;
    if (cmd_stb || cfg_we) begin
      if (q.size() == 0)
        chk(0, "R9", "unexpected event", {cmd_stb, cfg_we}, 0);
      else begin
        item_t it;
        logic [32:0] got;
        it = q.pop_front();
        got = it.is_cmd ? {29'b0, cmd} : {cfg_sel, cfg_wdata};
        chk(it.is_cmd == cmd_stb, it.tag, "event kind", cmd_stb, it.is_cmd);
        chk(got == it.val, it.tag, "event value", got, it.val);
        chk(rel == it.rel, it.tag, "event cycle", rel, it.rel);
      end
    end
    if (active) begin
      chk(cke == (rel >= t_nop), "R4", "cke level", cke, rel >= t_nop);
      chk(pad_hiz == (rel < t_done), "R7", "pad_hiz", pad_hiz, rel < t_done);
      chk(ref_interval == ((rel >= t_done) ? ref_prog : '0), "R7", "ref_interval",
          ref_interval, (rel >= t_done) ? ref_prog : '0);
      if (done && !done_seen) begin
        done_seen = 1;
        chk(rel == t_done, "R7", "done cycle", rel, t_done);
      end
    end
  end

  task automatic check_idle(input string req);
    chk(!cmd_stb && !cfg_we && !cke && !done && !ref_en, req, "idle controls",
        {cmd_stb, cfg_we, cke, done, ref_en}, 0);
    chk(pad_hiz && cmd == 4'b1111 && ref_interval == 0, req, "idle pads/cmd",
        {pad_hiz, cmd, ref_interval}, {1'b1, 4'b1111, 16'h0});
  endtask

  task automatic run(input logic [RW-1:0] p, input int abort_at, input bit poke);
    logic [3:0] codes[8] = '{4'b0011, 4'b0010, 4'b0100, 4'b0001,
                             4'b0010, 4'b0110, 4'b0110, 4'b0000};
    int gaps[8] = '{2, TRP+1, TMRD+1, TMRD+1, TRP+1, TRFC+1, TRFC+1, TMRD+1};
    int t;
    ref_prog = p;
    q.push_back('{0, {1'b0, 32'h0000_1000}, CAL, "R2 R3"});
    q.push_back('{0, {1'b1, 32'h0002_08F0}, CAL + 1, "R3"});
    t = CAL + 1 + DES + 1;
    t_nop = t;
    for (int i = 0; i < 8; i++) begin
      q.push_back('{1, {29'b0, codes[i]}, t, (i == 0) ? "R4 R5" : "R5 R6"});
      t += gaps[i];
    end
    t_done = t;
    done_seen = 0;
    @(negedge clk) start = 1;
    @(negedge clk) begin start = 0; t0 = cyc; active = 1; end
    if (abort_at > 0) begin
      repeat (abort_at) @(negedge clk);
      rst = 1; active = 0;
      @(posedge clk); #1 q.delete();
      @(negedge clk) check_idle("R10");
      rst = 0;
    end else begin
      if (poke) begin
        repeat (30) @(negedge clk);
        start = 1;                       // R9: ignored while running
        @(negedge clk) start = 0;
        repeat (t_done + 3 - 31) @(negedge clk);
      end else repeat (t_done + 3) @(negedge clk);
      chk(q.size() == 0, "R5", "events left", q.size(), 0);
      chk(done_seen && done, "R7", "done high", done, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 0;
    repeat (10) @(negedge clk);
    check_idle("R1");
    run(16'h0123, 0, 1);
    start = 1;                           // R9: ignored after done
    @(negedge clk) start = 0;
    repeat (80) @(negedge clk);
    chk(done && cke && !pad_hiz && ref_interval == 16'h0123, "R9", "post-done state",
        {done, cke, pad_hiz, ref_interval}, {3'b110, 16'h0123});
    rst = 1; active = 0;
    @(negedge clk) check_idle("R10");
    rst = 0;
    run(16'h00ff, 45, 0);
    repeat (5) @(negedge clk) check_idle("R1");
    run(16'hbeef, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule